// File: doc/BRIEF.md
# Two-Level Sticky Interrupt Collector

This block collects interrupt requests raised by individual modules into two 8-bit top-level status banks. Each bank has an enable bank of the same width. The block drives one interrupt line to the processor. Bank 0 carries the watchdog and four DMA channel requests. Bank 1 carries eight peripheral requests. A status bit latches while its request is high and stays set until software writes a 1 to it. A register-style read/write port gives access to all four registers.

Status is kept at two levels. A module keeps its request high until its own status is cleared. For that reason, software must clear the module-level source before it clears the top-level bit. If software clears the top-level bit while the request is still high, the bit sets again in the same cycle.

Top module: `irq_tree`

## Requirements
- R1: After reset, all status and enable bits are 0, `irq` is 0 and `rdata` is 0.
- R2: Source mapping. In bank 0, bit 0 is the watchdog (`wdg_req`) and bits 1 to 4 are DMA channels 0 to 3 (`dma_req[0..3]`). In bank 1, bit n is `per_req[n]`, in this order: USB, ADC, UART, SPI master, SPI slave, PWM, timer, parallel FIFO. A request that is high at a clock edge sets its status bit at that edge.
- R3: A status bit stays set until a write to its bank's status address has a 1 in that bit position. A write of 0 to a bit leaves that bit unchanged.
- R4: A request sets its status bit whatever the value of the enable bit. When a request is high in the same cycle as a write-1 clear of its bit, the bit stays set.
- R5: Each enable register can be written and read back. Its bits sit at the same positions as the status bits they gate. Bits 7:5 of bank 0 do not exist and read 0, in both the status and the enable register.
- R6: `irq` is a register. It is set one cycle after any bit is set in both a status register and its enable register, and it follows that OR with a one-cycle delay.
- R7: Address map: 0 is status 0, 1 is enable 0, 2 is status 1, 3 is enable 1. A read (`rd_en`) loads `rdata` at the clock edge with the value the register held before that edge. `rdata` holds its value when no read is made.
- R8: If a status bit is cleared while its request is still high, the bit stays set. Once the request has dropped, the same clear succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdg_req | input | 1 | Watchdog request, level high |
| dma_req | input | 4 | DMA channel requests, level high |
| per_req | input | 8 | Peripheral requests, level high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt line to the processor |

## Verification
The assertions check four things on every cycle: reserved bits stay zero, a set status bit stays set when no clear is written, a set wins over a clear in the same cycle, and a cleared bit is really cleared. They also check that enable writes take effect and that `irq` follows the gated OR one cycle later. Only the bench scenarios can show the following: that each source reaches its documented bit position, that the address map is correct, that a read returns the value from before the edge, and that the required order of clearing works from the module level upward.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
    localparam int unsigned DW    = 8;
    localparam int unsigned NBANK = 2;
    localparam int unsigned AW    = $clog2(2 * NBANK);

    typedef struct packed {
        logic [DW-1:0] st;
        logic [DW-1:0] en;
    } bank_state_t;

    typedef struct packed {
        logic [DW-1:0] rd;
    } port_state_t;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
    import irq_tree_pkg::*;
#(
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] req,
    input  logic          clr_we,
    input  logic          en_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] st_o,
    output logic [DW-1:0] en_o
);
    bank_state_t cur_q, nxt_d;
    logic [DW-1:0] clr_mask_d;

    always_comb begin
        nxt_d      = cur_q;
        clr_mask_d = clr_we ? wdata : '0;
        nxt_d.st   = ((cur_q.st & ~clr_mask_d) | req) & MASK;
        if (en_we) begin
            nxt_d.en = wdata & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st_o = cur_q.st;
    assign en_o = cur_q.en;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_o | en_o) & ~MASK) == '0); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((st_o & $past(st_o)) == $past(st_o))); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        |(req & MASK) |=> ((st_o & $past(req & MASK)) == $past(req & MASK))); // R4

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((st_o & $past(wdata & ~req)) == '0)); // R3

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_o == $past(wdata & MASK))); // R5
endmodule

// File: rtl/irq_regport.sv
module irq_regport
    import irq_tree_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic [NBANK-1:0][DW-1:0]  st_i,
    input  logic [NBANK-1:0][DW-1:0]  en_i,
    output logic [NBANK-1:0]          clr_we_o,
    output logic [NBANK-1:0]          en_we_o,
    output logic [DW-1:0]             rdata
);
    localparam int unsigned BW = AW - 1;

    port_state_t cur_q, nxt_d;
    logic [BW-1:0] bank_sel;
    logic          is_en;
    logic [DW-1:0] rd_val;

    assign bank_sel = addr[AW-1:1];
    assign is_en    = addr[0];

    always_comb begin
        clr_we_o = '0;
        en_we_o  = '0;
        rd_val   = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (int'(bank_sel) == b) begin
                clr_we_o[b] = wr_en && !is_en;
                en_we_o[b]  = wr_en && is_en;
                rd_val      = is_en ? en_i[b] : st_i[b];
            end
        end
        nxt_d = cur_q;
        if (rd_en) begin
            nxt_d.rd = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rdata = cur_q.rd;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R7

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_we_o, en_we_o})); // R7
endmodule

// File: rtl/irq_tree.sv
module irq_tree
    import irq_tree_pkg::*;
#(
    parameter int unsigned NUM_DMA = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wdg_req,
    input  logic [NUM_DMA-1:0] dma_req,
    input  logic [DW-1:0]      per_req,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic               irq
);
    localparam logic [DW-1:0] MASK0 = DW'((1 << (NUM_DMA + 1)) - 1);
    localparam logic [DW-1:0] MASK1 = '1;

    typedef struct packed {
        logic irq;
    } top_state_t;

    logic [NBANK-1:0][DW-1:0] req_bank;
    logic [NBANK-1:0][DW-1:0] st_w;
    logic [NBANK-1:0][DW-1:0] en_w;
    logic [NBANK-1:0]         clr_we;
    logic [NBANK-1:0]         en_we;
    top_state_t               cur_q, nxt_d;

    always_comb begin
        req_bank              = '0;
        req_bank[0][NUM_DMA:0] = {dma_req, wdg_req};
        req_bank[1]           = per_req;
    end

    irq_regport u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .st_i     (st_w),
        .en_i     (en_w),
        .clr_we_o (clr_we),
        .en_we_o  (en_we),
        .rdata    (rdata)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [DW-1:0] BMASK = (b == 0) ? MASK0 : MASK1;
        irq_bank #(.MASK(BMASK)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_bank[b]),
            .clr_we (clr_we[b]),
            .en_we  (en_we[b]),
            .wdata  (wdata),
            .st_o   (st_w[b]),
            .en_o   (en_w[b])
        );
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            nxt_d.irq = nxt_d.irq | (|(st_w[b] & en_w[b]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign irq = cur_q.irq;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(st_w[0] & en_w[0]) || |(st_w[1] & en_w[1])))); // R6

    AST_WDG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_req |=> st_w[0][0]); // R2
endmodule

// File: tb/irq_tree_tb.sv
module irq_tree_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdg_req = 1'b0;
    logic [3:0] dma_req = '0;
    logic [7:0] per_req = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    logic [7:0] m_st0 = '0, m_st1 = '0, m_en0 = '0, m_en1 = '0;

    always #10 clk = ~clk;

    irq_tree u_dut (
        .clk(clk), .rst_n(rst_n), .wdg_req(wdg_req), .dma_req(dma_req),
        .per_req(per_req), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tg);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tg, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] r0, input logic [7:0] r1, input logic we,
                       input logic re, input logic [1:0] a, input logic [7:0] wd,
                       input string tg);
        logic [7:0] old_rd;
        logic       old_irq;
        wdg_req = r0[0];
        dma_req = r0[4:1];
        per_req = r1;
        wr_en = we;
        rd_en = re;
        addr = a;
        wdata = wd;
        old_irq = (|(m_st0 & m_en0)) | (|(m_st1 & m_en1));
        case (a)
            2'd0: old_rd = m_st0;
            2'd1: old_rd = m_en0;
            2'd2: old_rd = m_st1;
            default: old_rd = m_en1;
        endcase
        @(posedge clk);
        m_st0 = ((m_st0 & ~((we && a == 2'd0) ? wd : 8'h00)) | r0) & 8'h1F;
        m_st1 = (m_st1 & ~((we && a == 2'd2) ? wd : 8'h00)) | r1;
        if (we && a == 2'd1) m_en0 = wd & 8'h1F;
        if (we && a == 2'd3) m_en1 = wd;
        @(negedge clk);
        chk({7'd0, irq}, {7'd0, old_irq}, "R6");
        if (re) chk(rdata, old_rd, tg);
    endtask

    task automatic idle();
        cyc(8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, "");
    endtask

    task automatic rd(input logic [1:0] a, input string tg);
        cyc(8'h00, 8'h00, 1'b0, 1'b1, a, 8'h00, tg);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc(8'h00, 8'h00, 1'b1, 1'b0, a, d, "");
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R1");
        chk(rdata, 8'h00, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 4; a++) rd(2'(a), "R1");

        // R2 and R3: each source alone, read both banks, clear it
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < (b == 0 ? 5 : 8); i++) begin
                if (b == 0) cyc(8'(1 << i), 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, "");
                else        cyc(8'h00, 8'(1 << i), 1'b0, 1'b0, 2'd0, 8'h00, "");
                rd(2'd0, "R2");
                rd(2'd2, "R2");
                wr(b == 0 ? 2'd0 : 2'd2, 8'(1 << i));
                rd(b == 0 ? 2'd0 : 2'd2, "R3");
            end
        end

        // R3: writing zeros has no effect
        cyc(8'h1F, 8'hFF, 1'b0, 1'b0, 2'd0, 8'h00, "");
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        rd(2'd0, "R3");
        rd(2'd2, "R3");
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'hFF);

        // R5: enable readback, reserved bits zero
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd1, "R5");
        rd(2'd3, "R5");
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h00);

        // R4: set with enable off, irq stays low
        cyc(8'h04, 8'h10, 1'b0, 1'b0, 2'd0, 8'h00, "");
        rd(2'd0, "R4");
        rd(2'd2, "R4");
        chk({7'd0, irq}, 8'h00, "R4");
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'hFF);

        // R4 and R8: clear while request high, then after it drops
        cyc(8'h00, 8'h08, 1'b0, 1'b0, 2'd0, 8'h00, "");
        cyc(8'h00, 8'h08, 1'b1, 1'b0, 2'd2, 8'h08, "");
        rd(2'd2, "R8");
        cyc(8'h02, 8'h00, 1'b1, 1'b0, 2'd0, 8'h02, "");
        rd(2'd0, "R4");
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h02);
        rd(2'd2, "R8");
        rd(2'd0, "R8");

        // R7: read in the cycle a request arrives returns the old value
        cyc(8'h00, 8'h40, 1'b0, 1'b1, 2'd2, 8'h00, "R7");
        rd(2'd2, "R7");
        idle();
        chk(rdata, 8'h40, "R7");
        wr(2'd2, 8'hFF);

        // R6: sweep all peripheral patterns against varied enables
        for (int p = 0; p < 256; p++) begin
            wr(2'd3, 8'(p) ^ 8'hA5);
            cyc(8'(p) & 8'h1F, 8'(p), 1'b0, 1'b0, 2'd0, 8'h00, "");
            wr(2'd1, 8'(p) >> 2);
            idle();
            wr(2'd2, 8'hFF);
            wr(2'd0, 8'hFF);
        end
        idle();
        chk({7'd0, irq}, 8'h00, "R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule